// File: doc/BRIEF.md
# Exception Preemption Mask Evaluator

This block decides, every clock cycle, whether the most urgent waiting exception may interrupt the running code of a small microcontroller-class core. The mask controls do not switch individual interrupt lines on or off. Each one sets a ceiling on the priority that may still run. The ceiling is merged with the priority of the handler that is running now, which gives one runnable threshold. The waiting exception is taken only if its priority is at or above that threshold. A numerically lower value means a more urgent priority.

The block keeps two priority registers. One holds the active handler priority and the other holds the pending priority. A pending request enters through a valid/ready port. The port stalls (ready low) only in the one cycle in which an entry is being decided. A request that arrives while another is already held keeps whichever of the two is more urgent. The core reports an exception return on a plain strobe that carries the priority to restore. All asynchronous exceptions use the same test. There is no separate fast-interrupt path.

Top module: `exc_preempt_gate`

## Requirements
- R1: After reset, the active and pending priorities both read 0x100 (idle), `take_o` is low, `req_ready_o` is high and `thresh_o` reads 0xFF.
- R2: While `fault_mask_i` is set, the mask ceiling is -2, whatever the other mask inputs are.
- R3: While `fault_mask_i` is clear and `prio_mask_i` is set, the mask ceiling is -1.
- R4: While both mask bits are clear and `base_pri_i` is nonzero, the mask ceiling is `base_pri_i` minus 2. A value of 1 therefore gives -1.
- R5: With no mask active the ceiling is 0x100. `thresh_o` is the smaller of the ceiling and the active priority minus 1, and it follows the mask inputs combinationally.
- R6: The pending exception is taken only when `thresh_o` is greater than or equal to the pending priority. A pending priority equal to the active priority is never taken.
- R7: A take shows as a one-cycle `take_o` pulse on the clock edge after the comparison first holds, with `take_prio_o` carrying the taken priority. On that same edge the active priority loads it and the pending priority returns to 0x100.
- R8: When `ret_valid_i` is high, the active priority loads `ret_prio_i` on the next edge, and no take fires in that cycle.
- R9: A request is accepted when `req_valid_i` and `req_ready_o` are both high. The pending register keeps the numerically lower of its held value and the new priority. `req_ready_o` is low exactly in a cycle in which a take is being decided.
- R10: All priorities on the ports are 10-bit two's complement, so -2, -1, 0..255 and 0x100 are distinct values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_mask_i | input | 1 | Fault-mask bit, ceiling -2 |
| prio_mask_i | input | 1 | Priority-mask bit, ceiling -1 |
| base_pri_i | input | 8 | Base-priority level, 0 means off |
| req_valid_i | input | 1 | Pending request valid |
| req_ready_o | output | 1 | Pending request can be accepted |
| req_prio_i | input | 10 | Priority of the request, signed |
| ret_valid_i | input | 1 | Exception return strobe |
| ret_prio_i | input | 10 | Active priority to restore on return, signed |
| thresh_o | output | 10 | Runnable priority threshold, signed |
| active_prio_o | output | 10 | Active handler priority, signed |
| pending_prio_o | output | 10 | Held pending priority, signed |
| take_o | output | 1 | One-cycle take-exception pulse |
| take_prio_o | output | 10 | Priority of the exception just taken |

## Verification
A wrong mask-priority order or a wrong offset in the ceiling appears on `thresh_o` in the same cycle as the mask input changes. An active register that was not loaded or restored correctly shifts `thresh_o` one cycle after the entry or return. A wrong compare or a held pending value that was lost appears as a missing, extra or wrongly valued `take_o` pulse two edges after the request. It can also appear later, as soon as the masks open. A take that fails to clear the pending register appears as a second pulse in the following cycle.

// File: rtl/excp_pkg.sv
package excp_pkg;
  localparam int PRIO_W = 8;
  localparam int SPW    = PRIO_W + 2;

  typedef logic signed [SPW-1:0] sprio_t;

  localparam sprio_t PRIO_IDLE       = sprio_t'(1 <<< PRIO_W);
  localparam sprio_t PRIO_FAULT_CEIL = sprio_t'(-2);
  localparam sprio_t PRIO_MASK_CEIL  = sprio_t'(-1);
  localparam sprio_t PRIO_ONE        = sprio_t'(1);
  localparam sprio_t PRIO_TWO        = sprio_t'(2);

  function automatic sprio_t smin(input sprio_t a, input sprio_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/mask_ceiling.sv
module mask_ceiling
  import excp_pkg::*;
(
  input  logic              fault_mask,
  input  logic              prio_mask,
  input  logic [PRIO_W-1:0] base_pri,
  output sprio_t            ceil
);
  sprio_t base_ext;

  always_comb begin
    base_ext = sprio_t'({2'b00, base_pri});
    if (fault_mask)
      ceil = PRIO_FAULT_CEIL;
    else if (prio_mask)
      ceil = PRIO_MASK_CEIL;
    else if (base_pri != '0)
      ceil = base_ext - PRIO_TWO;
    else
      ceil = PRIO_IDLE;
  end
endmodule

// File: rtl/thresh_combine.sv
module thresh_combine
  import excp_pkg::*;
(
  input  sprio_t ceil,
  input  sprio_t active,
  output sprio_t thresh
);
  sprio_t active_m1;

  always_comb begin
    active_m1 = active - PRIO_ONE;
    thresh    = smin(ceil, active_m1);
  end
endmodule

// File: rtl/prio_tracker.sv
module prio_tracker
  import excp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_accept,
  input  sprio_t req_prio,
  input  logic   take_fire,
  input  logic   ret_valid,
  input  sprio_t ret_prio,
  output sprio_t active,
  output sprio_t pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= PRIO_IDLE;
      pending <= PRIO_IDLE;
    end else begin
      if (ret_valid)
        active <= ret_prio;
      else if (take_fire)
        active <= pending;

      if (take_fire)
        pending <= PRIO_IDLE;
      else if (req_accept && (req_prio < pending))
        pending <= req_prio;
    end
  end
endmodule

// File: rtl/exc_preempt_gate.sv
module exc_preempt_gate
  import excp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fault_mask_i,
  input  logic                  prio_mask_i,
  input  logic [7:0]            base_pri_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic signed [9:0]     req_prio_i,
  input  logic                  ret_valid_i,
  input  logic signed [9:0]     ret_prio_i,
  output logic signed [9:0]     thresh_o,
  output logic signed [9:0]     active_prio_o,
  output logic signed [9:0]     pending_prio_o,
  output logic                  take_o,
  output logic signed [9:0]     take_prio_o
);
  sprio_t ceil_w, thresh_w, active_w, pending_w;
  logic   take_fire, req_accept;

  mask_ceiling u_ceil (
    .fault_mask (fault_mask_i),
    .prio_mask  (prio_mask_i),
    .base_pri   (base_pri_i),
    .ceil       (ceil_w)
  );

  thresh_combine u_comb (
    .ceil   (ceil_w),
    .active (active_w),
    .thresh (thresh_w)
  );

  // One test for every asynchronous exception; return and an entry in flight block it
  assign take_fire   = !take_o && !ret_valid_i && (thresh_w >= pending_w);
  assign req_ready_o = !take_fire;
  assign req_accept  = req_valid_i && req_ready_o;

  prio_tracker u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_accept (req_accept),
    .req_prio   (req_prio_i),
    .take_fire  (take_fire),
    .ret_valid  (ret_valid_i),
    .ret_prio   (ret_prio_i),
    .active     (active_w),
    .pending    (pending_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o      <= 1'b0;
      take_prio_o <= PRIO_IDLE;
    end else begin
      take_o <= take_fire;
      if (take_fire)
        take_prio_o <= pending_w;
    end
  end

  assign thresh_o       = thresh_w;
  assign active_prio_o  = active_w;
  assign pending_prio_o = pending_w;

  AST_FAULT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    fault_mask_i |-> (thresh_o <= PRIO_FAULT_CEIL)); // R2
  AST_PMASK_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_mask_i && prio_mask_i) |-> (thresh_o <= PRIO_MASK_CEIL)); // R3
  AST_BASE_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_mask_i && !prio_mask_i && base_pri_i != 8'd0)
      |-> (thresh_o <= sprio_t'({2'b00, base_pri_i}) - PRIO_TWO)); // R4
  AST_BELOW_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_o < active_prio_o); // R5
  AST_TAKE_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($past(thresh_o) >= take_prio_o)); // R6
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o); // R7
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(ret_valid_i)) |-> (pending_prio_o == PRIO_IDLE && active_prio_o == take_prio_o)); // R7
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid_i |=> (active_prio_o == $past(ret_prio_i))); // R8
  AST_RET_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid_i |=> !take_o); // R8
  AST_PEND_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_o && !$past(take_o)) |-> (pending_prio_o <= $past(pending_prio_o))); // R9
endmodule

// File: tb/sim_exc_preempt_gate.sv
module sim_exc_preempt_gate;
  localparam int CLK_P = 10;
  typedef logic signed [9:0] p_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fm = 1'b0, pm = 1'b0;
  logic [7:0] base = 8'd0;
  logic req_valid = 1'b0, ret_valid = 1'b0;
  p_t req_prio = '0, ret_prio = '0;
  logic req_ready, take;
  p_t thresh, active, pending, take_prio;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  p_t exp_q[$];
  logic prev_take = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  exc_preempt_gate u0 (
    .clk(clk), .rst_n(rst_n), .fault_mask_i(fm), .prio_mask_i(pm), .base_pri_i(base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_prio_i(req_prio),
    .ret_valid_i(ret_valid), .ret_prio_i(ret_prio), .thresh_o(thresh),
    .active_prio_o(active), .pending_prio_o(pending), .take_o(take), .take_prio_o(take_prio)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected takes from the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (take) begin
        if (prev_take) chk("R7", "pulse width", 2, 1);
        if (exp_q.size() == 0) chk("R6", "unexpected take prio", int'(take_prio), 999);
        else begin
          p_t e;
          e = exp_q.pop_front();
          chk("R7", "take prio", int'(take_prio), int'(e));
        end
      end
      prev_take = take;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(p_t p);
    @(negedge clk);
    req_valid = 1'b1; req_prio = p;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_ret(p_t p);
    @(negedge clk);
    ret_valid = 1'b1; ret_prio = p;
    @(negedge clk);
    ret_valid = 1'b0;
    #1;
  endtask

  task automatic q_empty(string req);
    #1;
    chk(req, "scoreboard left", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    chk("WD", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1); #1;
    chk("R1", "active", int'(active), 256);
    chk("R1", "pending", int'(pending), 256);
    chk("R1", "take", int'(take), 0);
    chk("R1", "ready", int'(req_ready), 1);
    chk("R1", "thresh", int'(thresh), 255);

    fm = 1; #1; chk("R2", "fault thresh", int'(thresh), -2);
    pm = 1; base = 8'd9; #1; chk("R2", "fault over others", int'(thresh), -2);
    fm = 0; #1; chk("R3", "pmask thresh", int'(thresh), -1);
    pm = 0; base = 8'd1; #1; chk("R4", "base one", int'(thresh), -1);
    base = 8'h40; #1; chk("R4", "base 0x40", int'(thresh), 62);
    base = 8'd0; #1; chk("R5", "no mask", int'(thresh), 255);

    // Plain take: 0x20
    exp_q.push_back(p_t'(32));
    send(p_t'(32)); #1;
    chk("R9", "ready low while deciding", int'(req_ready), 0);
    tick(2); q_empty("R7");
    chk("R7", "active after take", int'(active), 32);
    chk("R7", "pending cleared", int'(pending), 256);
    chk("R5", "thresh from active", int'(thresh), 31);

    // Equal priority must not preempt
    send(p_t'(32)); tick(3); q_empty("R6");
    chk("R6", "equal held", int'(pending), 32);
    send(p_t'(48)); tick(2); #1;
    chk("R9", "keeps more urgent", int'(pending), 32);
    exp_q.push_back(p_t'(16));
    send(p_t'(16)); tick(3); q_empty("R7");
    chk("R7", "nested active", int'(active), 16);
    chk("R7", "nested pending", int'(pending), 256);

    do_ret(p_t'(32));
    chk("R8", "return restore", int'(active), 32);
    chk("R5", "thresh after return", int'(thresh), 31);
    do_ret(p_t'(256));
    chk("R8", "return idle", int'(active), 256);

    // Base priority gating
    base = 8'h11; #1; chk("R4", "base 0x11", int'(thresh), 15);
    send(p_t'(16)); tick(3); q_empty("R4");
    chk("R4", "held by base", int'(pending), 16);
    exp_q.push_back(p_t'(16));
    @(negedge clk); base = 8'h12;
    tick(2); q_empty("R4");
    chk("R4", "taken when base opens", int'(active), 16);
    @(negedge clk); base = 8'd0;
    do_ret(p_t'(256));

    // Fixed negative levels
    fm = 1;
    send(p_t'(-1)); tick(3); q_empty("R2");
    chk("R2", "-1 held under fault mask", int'(pending), -1);
    exp_q.push_back(p_t'(-1));
    @(negedge clk); fm = 0; pm = 1;
    tick(2); q_empty("R3");
    chk("R10", "active -1", int'(active), -1);
    chk("R5", "thresh below -1", int'(thresh), -2);
    do_ret(p_t'(256));
    @(negedge clk); pm = 0;

    // Return cycle suppresses take
    fm = 1;
    send(p_t'(80)); tick(2);
    @(negedge clk); fm = 0; ret_valid = 1'b1; ret_prio = p_t'(64);
    @(negedge clk); ret_valid = 1'b0;
    tick(3); q_empty("R8");
    chk("R8", "held below restored", int'(pending), 80);
    exp_q.push_back(p_t'(80));
    do_ret(p_t'(256));
    tick(2); q_empty("R8");
    chk("R7", "taken after return", int'(active), 80);
    do_ret(p_t'(256));
    tick(2); q_empty("R7");

    finish_run();
  end
endmodule